// File: doc/BRIEF.md
# Miscellaneous Control Register with Alias Update Addresses

This block holds one 64-bit control word for an on-chip management controller and drives a level interrupt from it. Software reaches the word over a simple register bus at a base offset and at two alias offsets next to it. A write to the base offset replaces the word. A write to an alias changes the word in place, without a read-modify-write from software. The `GEN` parameter selects one of two chip generations, and each generation has its own offsets and alias meanings.

Only the sixteen most significant bits are storage. Each value that would be stored is first masked so that bits 47..0 are zero. The interrupt line is registered and always equals the stored bit 63. Any access the block does not implement, whether an unknown offset, a read of an alias, or a size other than eight bytes, leaves the word as it was and raises a one-cycle `unimpl_pulse`.

Top module: `misc_alias_reg`

## Requirements
- R1: A synchronous reset clears the stored word, deasserts `irq`, `rsp_valid` and `unimpl_pulse`, and a base read afterwards returns zero.
- R2: An 8-byte write to the base offset (0x4020 when GEN=0, 0x6080 when GEN=1) stores the write data ANDed with 0xFFFF_0000_0000_0000. Bus bit 63 carries register bit 63, so the most significant byte is on lanes 63..56.
- R3: With GEN=0, a write to base+1 stores the current word ANDed with the write data, after the mask.
- R4: In both generations, a write to base+2 stores the current word ORed with the write data, after the mask.
- R5: With GEN=1, a write to base+1 clears the whole word, whatever the write data is.
- R6: `irq` equals bit 63 of the stored word. It takes the new value on the same clock edge that samples the write, so it is visible one cycle after the strobe.
- R7: A read of the base offset gives `rsp_valid` high for one cycle, one cycle after the strobe, with `rsp_rdata` equal to the stored word.
- R8: A read of any other offset returns zero on `rsp_rdata` with `rsp_valid` high, and pulses `unimpl_pulse` for exactly one cycle.
- R9: A write to an unmapped offset leaves the stored word unchanged and pulses `unimpl_pulse`.
- R10: An access whose `req_size` is not 8 bytes is rejected. The word is unchanged, read data is zero, and `unimpl_pulse` pulses.
- R11: The word offset is the byte address shifted right by three, so address bits 2..0 do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SIZE_W | Access size in bytes |
| req_wdata | input | DATA_W | Write data, big-endian lanes |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | DATA_W | Read data |
| unimpl_pulse | output | 1 | One-cycle flag for a rejected access |
| irq | output | 1 | Level interrupt, equal to stored bit 63 |

## Verification
If the stored word is corrupted, the next base read shows it in `rsp_rdata` one cycle after the strobe. If the corruption touches bit 63, `irq` shows it on the same edge. A wrong alias decode leaves a stored value that does not match the AND, OR or clear result. The bench therefore reads the base offset after every vector, so such a fault shows up within two accesses. A decode that is too loose or too strict shows up on `unimpl_pulse` in the cycle right after the faulty access.

// File: rtl/misc_alias_pkg.sv
package misc_alias_pkg;

    // Decoded meaning of one bus access
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_AND,
        OP_OR,
        OP_CLEAR,
        OP_READ,
        OP_BAD
    } acc_op_e;

endpackage

// File: rtl/misc_alias_decode.sv
module misc_alias_decode
    import misc_alias_pkg::*;
#(
    parameter int GEN       = 0,
    parameter int OFF_W     = 17,
    parameter int SIZE_W    = 4,
    parameter int FULL_SIZE = 8,
    parameter int BASE_G0   = 'h4020,
    parameter int BASE_G1   = 'h6080
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFF_W-1:0]  word_off,
    input  logic [SIZE_W-1:0] req_size,
    output acc_op_e           op
);

    localparam int BASE_OFF   = (GEN == 0) ? BASE_G0 : BASE_G1;
    localparam logic [OFF_W-1:0] OFF_BASE   = OFF_W'(BASE_OFF);
    localparam logic [OFF_W-1:0] OFF_ALIAS1 = OFF_W'(BASE_OFF + 1);
    localparam logic [OFF_W-1:0] OFF_ALIAS2 = OFF_W'(BASE_OFF + 2);

    acc_op_e alias1_op;

    generate
        if (GEN == 0) begin : g_and_alias
            assign alias1_op = OP_AND;
        end else begin : g_clear_alias
            assign alias1_op = OP_CLEAR;
        end
    endgenerate

    always_comb begin
        op = OP_IDLE;
        if (req_valid) begin
            if (req_size != SIZE_W'(FULL_SIZE)) begin
                op = OP_BAD;
            end else if (!req_write) begin
                op = (word_off == OFF_BASE) ? OP_READ : OP_BAD;
            end else if (word_off == OFF_BASE) begin
                op = OP_LOAD;
            end else if (word_off == OFF_ALIAS1) begin
                op = alias1_op;
            end else if (word_off == OFF_ALIAS2) begin
                op = OP_OR;
            end else begin
                op = OP_BAD;
            end
        end
    end

endmodule

// File: rtl/misc_alias_update.sv
module misc_alias_update
    import misc_alias_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMPL_W = 16
) (
    input  acc_op_e           op,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    output logic              store_en,
    output logic [DATA_W-1:0] next_val
);

    localparam int LOW_W = DATA_W - IMPL_W;
    localparam logic [DATA_W-1:0] KEEP_MASK = {{IMPL_W{1'b1}}, {LOW_W{1'b0}}};

    logic [DATA_W-1:0] raw;

    always_comb begin
        raw      = cur;
        store_en = 1'b0;
        unique case (op)
            OP_LOAD:  begin raw = wdata;       store_en = 1'b1; end
            OP_AND:   begin raw = cur & wdata; store_en = 1'b1; end
            OP_OR:    begin raw = cur | wdata; store_en = 1'b1; end
            OP_CLEAR: begin raw = '0;          store_en = 1'b1; end
            default:  begin raw = cur;         store_en = 1'b0; end
        endcase
        next_val = raw & KEEP_MASK;
    end

endmodule

// File: rtl/misc_alias_reg.sv
module misc_alias_reg
    import misc_alias_pkg::*;
#(
    parameter int GEN    = 0,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 64,
    parameter int IMPL_W = 16,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              unimpl_pulse,
    output logic              irq
);

    localparam int LANE_BITS = 3;
    localparam int OFF_W     = ADDR_W - LANE_BITS;
    localparam int FULL_SIZE = DATA_W / 8;

    acc_op_e           dec_op;
    logic              store_en;
    logic [DATA_W-1:0] next_val;
    logic [DATA_W-1:0] stored_q;
    logic [LANE_BITS-1:0] byte_lane_unused;

    assign byte_lane_unused = req_addr[LANE_BITS-1:0];

    misc_alias_decode #(
        .GEN       (GEN),
        .OFF_W     (OFF_W),
        .SIZE_W    (SIZE_W),
        .FULL_SIZE (FULL_SIZE)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .word_off  (req_addr[ADDR_W-1:LANE_BITS]),
        .req_size  (req_size),
        .op        (dec_op)
    );

    misc_alias_update #(
        .DATA_W (DATA_W),
        .IMPL_W (IMPL_W)
    ) u_update (
        .op       (dec_op),
        .cur      (stored_q),
        .wdata    (req_wdata),
        .store_en (store_en),
        .next_val (next_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q <= '0;
            irq      <= 1'b0;
        end else if (store_en) begin
            stored_q <= next_val;
            irq      <= next_val[DATA_W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            unimpl_pulse <= 1'b0;
        end else begin
            rsp_valid    <= req_valid && !req_write;
            rsp_rdata    <= (dec_op == OP_READ) ? stored_q : '0;
            unimpl_pulse <= (dec_op == OP_BAD);
        end
    end

endmodule

// File: rtl/misc_alias_chk.sv
module misc_alias_chk
    import misc_alias_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMPL_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] req_wdata,
    input acc_op_e           op,
    input logic [DATA_W-1:0] stored,
    input logic              irq,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              unimpl_pulse
);

    localparam int LOW_W = DATA_W - IMPL_W;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (stored == '0 && !irq && !rsp_valid && !unimpl_pulse));

    // R2
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stored[LOW_W-1:0] == '0);

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> stored[DATA_W-1:LOW_W] == $past(req_wdata[DATA_W-1:LOW_W]));

    // R5
    clear_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLEAR) |=> (stored == '0 && !irq));

    // R6
    irq_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> irq == $past(req_wdata[DATA_W-1]));

    // R9
    bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BAD) |=> ($stable(stored) && unimpl_pulse));

    // R8
    flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (op != OP_BAD) |=> !unimpl_pulse);

    // R7
    read_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ) |=> (rsp_valid && rsp_rdata == $past(stored)));

endmodule

bind misc_alias_reg misc_alias_chk #(
    .DATA_W (DATA_W),
    .IMPL_W (IMPL_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_wdata    (req_wdata),
    .op           (dec_op),
    .stored       (stored_q),
    .irq          (irq),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .unimpl_pulse (unimpl_pulse)
);

// File: tb/sim_misc_alias_reg.sv
`timescale 1ns/1ps
module sim_misc_alias_reg;

    localparam int ADDR_W = 20;
    localparam int NV     = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              q_valid [2];
    logic              q_write [2];
    logic [ADDR_W-1:0] q_addr  [2];
    logic [3:0]        q_size  [2];
    logic [63:0]       q_wdata [2];
    logic              r_valid [2];
    logic [63:0]       r_rdata [2];
    logic              r_flag  [2];
    logic              r_irq   [2];

    int checks = 0;
    int errors = 0;

    misc_alias_reg #(.GEN(0)) u0 (
        .clk(clk), .rst(rst), .req_valid(q_valid[0]), .req_write(q_write[0]),
        .req_addr(q_addr[0]), .req_size(q_size[0]), .req_wdata(q_wdata[0]),
        .rsp_valid(r_valid[0]), .rsp_rdata(r_rdata[0]),
        .unimpl_pulse(r_flag[0]), .irq(r_irq[0])
    );

    misc_alias_reg #(.GEN(1)) u1 (
        .clk(clk), .rst(rst), .req_valid(q_valid[1]), .req_write(q_write[1]),
        .req_addr(q_addr[1]), .req_size(q_size[1]), .req_wdata(q_wdata[1]),
        .rsp_valid(r_valid[1]), .rsp_rdata(r_rdata[1]),
        .unimpl_pulse(r_flag[1]), .irq(r_irq[1])
    );

    // {inst, write, word offset, data, expected stored word, expected flag}
    localparam logic [146:0] VEC [NV] = '{
        {1'b0, 1'b1, 16'h4020, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_0000_0000, 1'b0},
        {1'b0, 1'b1, 16'h4021, 64'h0F0F_1234_0000_0000, 64'h0F0F_0000_0000_0000, 1'b0},
        {1'b0, 1'b1, 16'h4022, 64'h8000_0000_0000_00FF, 64'h8F0F_0000_0000_0000, 1'b0},
        {1'b0, 1'b0, 16'h4020, 64'h0,                   64'h8F0F_0000_0000_0000, 1'b0},
        {1'b0, 1'b1, 16'h4023, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8F0F_0000_0000_0000, 1'b1},
        {1'b0, 1'b0, 16'h4021, 64'h0,                   64'h8F0F_0000_0000_0000, 1'b1},
        {1'b0, 1'b1, 16'h4021, 64'h7FFF_0000_0000_0000, 64'h0F0F_0000_0000_0000, 1'b0},
        {1'b1, 1'b1, 16'h6080, 64'hA5A5_5A5A_0000_0001, 64'hA5A5_0000_0000_0000, 1'b0},
        {1'b1, 1'b1, 16'h6082, 64'h0A0A_0000_0000_0000, 64'hAFAF_0000_0000_0000, 1'b0},
        {1'b1, 1'b1, 16'h6081, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b0},
        {1'b1, 1'b1, 16'h6082, 64'h8001_0000_FFFF_0000, 64'h8001_0000_0000_0000, 1'b0},
        {1'b1, 1'b0, 16'h6080, 64'h0,                   64'h8001_0000_0000_0000, 1'b0},
        {1'b1, 1'b1, 16'h4020, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8001_0000_0000_0000, 1'b1},
        {1'b1, 1'b0, 16'h6082, 64'h0,                   64'h8001_0000_0000_0000, 1'b1}
    };

    localparam string TAG [NV] = '{
        "R2", "R3", "R4", "R7", "R9", "R8", "R3",
        "R2", "R4", "R5", "R4", "R7", "R9", "R8"
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input int inst, input logic wr, input logic [ADDR_W-1:0] addr,
                          input logic [63:0] data, input logic [3:0] size,
                          output logic [63:0] rd, output logic rv,
                          output logic fl, output logic iq);
        @(negedge clk);
        q_valid[inst] = 1'b1;
        q_write[inst] = wr;
        q_addr[inst]  = addr;
        q_size[inst]  = size;
        q_wdata[inst] = data;
        @(negedge clk);
        q_valid[inst] = 1'b0;
        rd = r_rdata[inst];
        rv = r_valid[inst];
        fl = r_flag[inst];
        iq = r_irq[inst];
    endtask

    function automatic logic [ADDR_W-1:0] baddr(input logic [15:0] off);
        return {1'b0, off, 3'b000};
    endfunction

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        logic rv, fl, iq;
        logic [15:0] base [2];
        base[0] = 16'h4020;
        base[1] = 16'h6080;
        for (int i = 0; i < 2; i++) begin
            q_valid[i] = 1'b0; q_write[i] = 1'b0; q_addr[i] = '0;
            q_size[i] = 4'd8;  q_wdata[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state at the ports, then a base read
        for (int i = 0; i < 2; i++) begin
            check("R1 irq", {63'b0, r_irq[i]}, 64'h0);
            check("R1 flag", {63'b0, r_flag[i]}, 64'h0);
            check("R1 rsp_valid", {63'b0, r_valid[i]}, 64'h0);
            access(i, 1'b0, baddr(base[i]), 64'h0, 4'd8, rd, rv, fl, iq);
            check("R1 read", rd, 64'h0);
        end

        // table walk; every vector is followed by a base read
        for (int v = 0; v < NV; v++) begin
            int inst;
            logic wr, ef;
            logic [15:0] off;
            logic [63:0] dat, ev;
            inst = int'(VEC[v][146]);
            wr   = VEC[v][145];
            off  = VEC[v][144:129];
            dat  = VEC[v][128:65];
            ev   = VEC[v][64:1];
            ef   = VEC[v][0];
            access(inst, wr, baddr(off), dat, 4'd8, rd, rv, fl, iq);
            check({TAG[v], " flag"}, {63'b0, fl}, {63'b0, ef});
            if (wr) begin
                // R6: irq follows bit 63 one cycle after the strobe
                check("R6 irq", {63'b0, iq}, {63'b0, ev[63]});
            end else begin
                check({TAG[v], " rsp_valid"}, {63'b0, rv}, 64'h1);
                check({TAG[v], " rdata"}, rd, ef ? 64'h0 : ev);
            end
            access(inst, 1'b0, baddr(base[inst]), 64'h0, 4'd8, rd, rv, fl, iq);
            check({TAG[v], " stored"}, rd, ev);
        end

        // R8: flag lasts exactly one cycle
        access(0, 1'b1, baddr(16'h4030), 64'h1, 4'd8, rd, rv, fl, iq);
        check("R8 pulse", {63'b0, fl}, 64'h1);
        @(negedge clk);
        check("R8 pulse end", {63'b0, r_flag[0]}, 64'h0);

        // R10: partial-size write and read are rejected
        access(0, 1'b1, baddr(16'h4020), 64'hFFFF_FFFF_FFFF_FFFF, 4'd4, rd, rv, fl, iq);
        check("R10 write flag", {63'b0, fl}, 64'h1);
        check("R10 irq", {63'b0, iq}, 64'h0);
        access(0, 1'b0, baddr(16'h4020), 64'h0, 4'd2, rd, rv, fl, iq);
        check("R10 read data", rd, 64'h0);
        check("R10 read flag", {63'b0, fl}, 64'h1);
        access(0, 1'b0, baddr(16'h4020), 64'h0, 4'd8, rd, rv, fl, iq);
        check("R10 stored", rd, 64'h0F0F_0000_0000_0000);

        // R11: low address bits do not change the decode
        access(0, 1'b1, baddr(16'h4020) | 20'h5, 64'hC3C3_0000_0000_0000, 4'd8, rd, rv, fl, iq);
        check("R11 flag", {63'b0, fl}, 64'h0);
        check("R11 irq", {63'b0, iq}, 64'h1);
        access(0, 1'b0, baddr(16'h4020) | 20'h7, 64'h0, 4'd8, rd, rv, fl, iq);
        check("R11 read", rd, 64'hC3C3_0000_0000_0000);

        // R5: clear alias with zero data still clears
        access(1, 1'b1, baddr(16'h6081), 64'h0, 4'd8, rd, rv, fl, iq);
        check("R5 irq", {63'b0, iq}, 64'h0);
        access(1, 1'b0, baddr(16'h6080), 64'h0, 4'd8, rd, rv, fl, iq);
        check("R5 stored", rd, 64'h0);

        // R1: reset while the word and irq are set
        access(1, 1'b1, baddr(16'h6080), 64'hFFFF_0000_0000_0000, 4'd8, rd, rv, fl, iq);
        check("R6 irq set", {63'b0, iq}, 64'h1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {63'b0, r_irq[1]}, 64'h0);
        access(1, 1'b0, baddr(16'h6080), 64'h0, 4'd8, rd, rv, fl, iq);
        check("R1 stored after reset", rd, 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule